// File: doc/BRIEF.md
# Sample Buffer Fill Level and Interrupt Flag Generator

This block sits next to the pointer logic of a 64-entry sample buffer. A sensor front end fills the buffer and a host drains it over a serial link. Each cycle the block takes the current write and read pointers and the strobes accepted in that cycle. It keeps a registered fill level from 0 to 64. When the buffer is full the two pointers are equal, so a full register decides between level 0 and level 64.

From the level it produces the status and interrupt flags that the host polls or takes as interrupts: full, empty, watermark, stop, full-interrupt and empty-interrupt. The mode input selects one of four behaviours:
- bypass, where everything is held inactive;
- streaming, where old samples are overwritten and the buffer never stops;
- halt-on-full;
- trigger-armed, where halting is held back until a trigger event has been seen.

A restart pulse brings all state back to its post-reset values so that a new capture cycle can begin.

Top module: `fifo_flag_gen`

## Requirements
- R1: At each rising edge, `level` becomes the occupancy after that cycle's strobes. The start value is the pointer difference (`wr_ptr` − `rd_ptr`) modulo 64, or 64 while `full` is set. One is added for `wr_stb` and one is subtracted for `rd_stb`. A read is ignored when the start value is 0. A lone write at 64 leaves 64. A read together with a write leaves the level unchanged unless the start value is 0.
- R2: `full` is 1 exactly when `level` is 64, even though the pointers are equal at that point.
- R3: After synchronous reset `level` is 0, `empty` is 1 and every other flag is 0. Outside bypass, `empty` is 1 exactly when `level` is 0.
- R4: `wm_flag` sets when the new level is greater than `wm_thresh` (0..63) and clears when it is less. When the level equals the threshold, the flag keeps its value.
- R5: In halt-on-full mode (`mode` = 2'b10), `stop` rises on the edge at which the level reaches 64. It stays set until restart or reset, even after reads.
- R6: In trigger-armed mode (`mode` = 2'b11), `stop` stays 0 until a `trigger` pulse has been seen. From that edge on, `stop` sets whenever the level is 64, including the case where the buffer was already full when the trigger came.
- R7: In streaming mode (`mode` = 2'b01), `stop` is always 0, and writes at level 64 keep the level at 64.
- R8: `full_irq` sets on the edge at which the level goes from below 64 to 64. It clears on the edge after any `rd_stb`.
- R9: `empty_irq` sets on the edge at which a read brings a nonzero level to 0. It clears on the edge after any `wr_stb`. A read while the buffer is already empty does not set it.
- R10: A `restart` pulse returns level, flags, interrupts and the trigger memory to their reset values on the next edge.
- R11: In bypass mode (`mode` = 2'b00), `level` is 0 and all six flags, including `empty`, are 0 from the next edge on. Strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 bypass, 01 streaming, 10 halt-on-full, 11 trigger-armed |
| wm_thresh | input | 6 | Watermark threshold, 0..63 |
| trigger | input | 1 | Trigger event pulse (trigger-armed mode) |
| restart | input | 1 | Clear interrupts and restart the capture cycle |
| wr_stb | input | 1 | A write is accepted this cycle |
| rd_stb | input | 1 | The host reads an entry this cycle |
| wr_ptr | input | 6 | Current write pointer |
| rd_ptr | input | 6 | Current read pointer |
| level | output | 7 | Registered fill level, 0..64 |
| full | output | 1 | Buffer holds 64 entries |
| empty | output | 1 | Buffer holds no entry |
| wm_flag | output | 1 | Level is above the watermark threshold |
| stop | output | 1 | Capture halted |
| full_irq | output | 1 | Full interrupt |
| empty_irq | output | 1 | Empty interrupt |

## Verification
The level logic is driven with several patterns:
- single writes, single reads and long fill runs, which tell counting apart from the pointer wrap at 64, where only the full register tells full from empty;
- simultaneous read and write, which must leave the level unchanged;
- writes into a full streaming buffer, which must saturate;
- reads of an empty buffer, which must be ignored.

The watermark threshold is set at 10, 0 and 63, so that the above, below and equal cases are each reached from both directions. The stop output is tried in all four modes, with the trigger arriving both before and after the fill, and is read again after reads and after a restart to show that it is sticky and that the trigger memory is cleared.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_STREAM = 2'b01,
    MODE_HALT   = 2'b10,
    MODE_TRIG   = 2'b11
  } ffg_mode_e;
endpackage

// File: rtl/ffg_level.sv
// Occupancy tracking: start value from the pointers, with the full register
// resolving the aliased equal-pointer case.
module ffg_level #(
  parameter int PTR_W = 6,
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             bypass,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] lvl_nxt,
  output logic             cur_zero,
  output logic             full_q,
  output logic [LVL_W-1:0] lvl_q
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(1 << PTR_W);

  logic [LVL_W-1:0] cur;
  logic             rd_ok;

  assign cur      = full_q ? FULL_LVL : {1'b0, wr_ptr - rd_ptr};
  assign cur_zero = (cur == '0);
  assign rd_ok    = rd_stb && !cur_zero;

  always_comb begin
    lvl_nxt = cur;
    if (wr_stb && !rd_ok) begin
      lvl_nxt = (cur == FULL_LVL) ? cur : cur + LVL_W'(1);
    end else if (rd_ok && !wr_stb) begin
      lvl_nxt = cur - LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart || bypass) begin
      lvl_q  <= '0;
      full_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_nxt;
      full_q <= (lvl_nxt == FULL_LVL);
    end
  end
endmodule

// File: rtl/ffg_wmark.sv
// Watermark comparator with hold-on-equal behaviour.
module ffg_wmark #(
  parameter int PTR_W = 6,
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [LVL_W-1:0] lvl_nxt,
  input  logic [PTR_W-1:0] thresh,
  output logic             wm_q
);
  logic [LVL_W-1:0] thr_ext;
  assign thr_ext = {1'b0, thresh};

  always_ff @(posedge clk) begin
    if (clr) begin
      wm_q <= 1'b0;
    end else if (lvl_nxt > thr_ext) begin
      wm_q <= 1'b1;
    end else if (lvl_nxt < thr_ext) begin
      wm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ffg_irq.sv
// Empty flag, stop gating by mode and trigger, full/empty interrupts.
module ffg_irq
  import ffg_pkg::*;
#(
  parameter int PTR_W = 6,
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  ffg_mode_e        mode,
  input  logic             trigger,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             cur_zero,
  input  logic             full_q,
  input  logic [LVL_W-1:0] lvl_nxt,
  output logic             empty_q,
  output logic             stop_q,
  output logic             fi_q,
  output logic             ei_q
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(1 << PTR_W);

  logic bypass, nxt_full, fill_evt, drain_evt, armed_q, armed_nxt;

  assign bypass    = (mode == MODE_BYPASS);
  assign nxt_full  = (lvl_nxt == FULL_LVL);
  assign fill_evt  = !full_q && nxt_full;
  assign drain_evt = !cur_zero && (lvl_nxt == '0);
  assign armed_nxt = armed_q || trigger;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
    end else if (bypass) begin
      empty_q <= 1'b0;
    end else if (restart) begin
      empty_q <= 1'b1;
    end else begin
      empty_q <= (lvl_nxt == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart || mode != MODE_TRIG) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      stop_q <= 1'b0;
    end else begin
      case (mode)
        MODE_HALT: stop_q <= stop_q || nxt_full;
        MODE_TRIG: stop_q <= stop_q || (nxt_full && armed_nxt);
        default:   stop_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart || bypass) begin
      fi_q <= 1'b0;
      ei_q <= 1'b0;
    end else begin
      if (rd_stb)        fi_q <= 1'b0;
      else if (fill_evt) fi_q <= 1'b1;
      if (wr_stb)         ei_q <= 1'b0;
      else if (drain_evt) ei_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
  import ffg_pkg::*;
#(
  parameter int PTR_W = 6,
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [PTR_W-1:0] wm_thresh,
  input  logic             trigger,
  input  logic             restart,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             wm_flag,
  output logic             stop,
  output logic             full_irq,
  output logic             empty_irq
);
  ffg_mode_e        mode_e;
  logic             bypass, cur_zero;
  logic [LVL_W-1:0] lvl_nxt;

  assign mode_e = ffg_mode_e'(mode);
  assign bypass = (mode_e == MODE_BYPASS);

  ffg_level #(.PTR_W(PTR_W)) u_level (
    .clk(clk), .rst(rst), .restart(restart), .bypass(bypass),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .lvl_nxt(lvl_nxt), .cur_zero(cur_zero), .full_q(full), .lvl_q(level)
  );

  ffg_wmark #(.PTR_W(PTR_W)) u_wmark (
    .clk(clk), .clr(rst || restart || bypass), .lvl_nxt(lvl_nxt),
    .thresh(wm_thresh), .wm_q(wm_flag)
  );

  ffg_irq #(.PTR_W(PTR_W)) u_irq (
    .clk(clk), .rst(rst), .restart(restart), .mode(mode_e),
    .trigger(trigger), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .cur_zero(cur_zero), .full_q(full), .lvl_nxt(lvl_nxt),
    .empty_q(empty), .stop_q(stop), .fi_q(full_irq), .ei_q(empty_irq)
  );
endmodule

// File: rtl/ffg_chk.sv
module ffg_chk #(
  parameter int PTR_W = 6,
  localparam int LVL_W = PTR_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             restart,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [LVL_W-1:0] level,
  input logic             full,
  input logic             empty,
  input logic             wm_flag,
  input logic             stop,
  input logic             full_irq,
  input logic             empty_irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(1 << PTR_W);

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  // R2
  full_level_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> level == FULL_LVL);

  // R3
  empty_level_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> level == '0);

  // R7
  stream_nostop_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 || mode == 2'b00) |=> !stop);

  // R8
  fi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !full_irq);

  // R9
  ei_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !empty_irq);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (level == '0 && !full && !stop && !full_irq && !empty_irq));

  // R11
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> (level == '0 && !full && !empty && !wm_flag && !full_irq && !empty_irq));
endmodule

bind fifo_flag_gen ffg_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .mode(mode), .restart(restart),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .level(level), .full(full),
  .empty(empty), .wm_flag(wm_flag), .stop(stop),
  .full_irq(full_irq), .empty_irq(empty_irq)
);

// File: tb/fifo_flag_gen_tb.sv
module fifo_flag_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       w;
    logic       r;
    logic [7:0] cnt;
    logic [6:0] lvl;
    logic       full;
    logic       empty;
    logic       wm;
    logic       fi;
    logic       ei;
  } seg_t;

  // Streaming mode, threshold 10, starting from reset.
  localparam int NSEG = 12;
  localparam seg_t SEGS [NSEG] = '{
    '{1'b1, 1'b0, 8'd10, 7'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 equal holds 0
    '{1'b1, 1'b0, 8'd1,  7'd11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 above
    '{1'b0, 1'b1, 8'd1,  7'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 equal holds 1
    '{1'b0, 1'b1, 8'd1,  7'd9,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 below
    '{1'b0, 1'b1, 8'd9,  7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 drained
    '{1'b0, 1'b1, 8'd1,  7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R1/R9 read on empty
    '{1'b1, 1'b0, 8'd1,  7'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 write clears
    '{1'b1, 1'b0, 8'd63, 7'd64, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2/R8 fill, wrap
    '{1'b1, 1'b0, 8'd3,  7'd64, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 overwrite
    '{1'b0, 1'b1, 8'd1,  7'd63, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 read clears
    '{1'b1, 1'b1, 8'd1,  7'd63, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 both
    '{1'b1, 1'b0, 8'd1,  7'd64, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}  // R8 refill
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b01;
  logic [5:0] wm_thresh = 6'd10;
  logic       trigger = 1'b0, restart = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [5:0] wr_ptr = '0, rd_ptr = '0;
  logic [6:0] level;
  logic       full, empty, wm_flag, stop, full_irq, empty_irq;

  int n_run = 0, n_fail = 0;
  int occ = 0;
  logic [5:0] wp = '0, rp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_flag_gen dut_i (
    .clk(clk), .rst(rst), .mode(mode), .wm_thresh(wm_thresh),
    .trigger(trigger), .restart(restart), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level), .full(full),
    .empty(empty), .wm_flag(wm_flag), .stop(stop),
    .full_irq(full_irq), .empty_irq(empty_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One accepted operation; the pointer model mimics the pointer block.
  task automatic op(input logic w, input logic r, input logic t);
    @(negedge clk);
    wr_stb = w; rd_stb = r; trigger = t; wr_ptr = wp; rd_ptr = rp;
    @(posedge clk);
    if (mode != 2'b00) begin
      if (w && r) begin
        wp++;
        if (occ == 0) occ = 1; else rp++;
      end else if (w) begin
        wp++;
        if (occ == 64) rp++; else occ++;
      end else if (r && occ > 0) begin
        rp++;
        occ--;
      end
    end
  endtask

  // Return to idle and sample one half period after the edge.
  task automatic idle();
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; trigger = 1'b0; restart = 1'b0;
    wr_ptr = wp; rd_ptr = rp;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(posedge clk);
    wp = '0; rp = '0; occ = 0;
    idle();
  endtask

  task automatic check_all(input int lv, input logic fu, input logic em,
                           input logic wm, input logic st, input logic fi,
                           input logic ei, input string stag);
    chk("R1 level", int'(level), lv);
    chk("R2 full", int'(full), int'(fu));
    chk("R3 empty", int'(empty), int'(em));
    chk("R4 wm_flag", int'(wm_flag), int'(wm));
    chk({stag, " stop"}, int'(stop), int'(st));
    chk("R8 full_irq", int'(full_irq), int'(fi));
    chk("R9 empty_irq", int'(empty_irq), int'(ei));
  endtask

  task automatic burst(input logic w, input logic r, input int n);
    for (int i = 0; i < n; i++) op(w, r, 1'b0);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    check_all(0, 0, 1, 0, 0, 0, 0, "R3");

    for (int s = 0; s < NSEG; s++) begin
      burst(SEGS[s].w, SEGS[s].r, int'(SEGS[s].cnt));
      check_all(int'(SEGS[s].lvl), SEGS[s].full, SEGS[s].empty, SEGS[s].wm,
                1'b0, SEGS[s].fi, SEGS[s].ei, "R7");
    end

    // R10 restart from full
    do_restart();
    check_all(0, 0, 1, 0, 0, 0, 0, "R10");

    // R5 halt-on-full: stop rises exactly at fill and is sticky
    mode = 2'b10;
    burst(1'b1, 1'b0, 63);
    chk("R5 stop before fill", int'(stop), 0);
    burst(1'b1, 1'b0, 1);
    check_all(64, 1, 0, 1, 1, 1, 0, "R5");
    burst(1'b0, 1'b1, 1);
    check_all(63, 0, 0, 1, 1, 0, 0, "R5 sticky");
    do_restart();
    chk("R10 stop cleared", int'(stop), 0);

    // R6 trigger-armed: fill first, trigger later
    mode = 2'b11;
    burst(1'b1, 1'b0, 64);
    check_all(64, 1, 0, 1, 0, 1, 0, "R6 unarmed");
    op(1'b0, 1'b0, 1'b1);
    idle();
    chk("R6 stop after trigger", int'(stop), 1);

    // R6/R10 trigger first, restart cleared earlier arming
    do_restart();
    burst(1'b1, 1'b0, 64);
    chk("R10 trigger memory cleared", int'(stop), 0);
    do_restart();
    op(1'b0, 1'b0, 1'b1);
    burst(1'b1, 1'b0, 63);
    chk("R6 armed not full", int'(stop), 0);
    burst(1'b1, 1'b0, 1);
    chk("R6 armed at fill", int'(stop), 1);

    // R11 bypass: everything inactive, strobes ignored
    do_restart();
    mode = 2'b00;
    burst(1'b1, 1'b0, 5);
    check_all(0, 0, 0, 0, 0, 0, 0, "R11");

    // R4 threshold 0: equal keeps the flag set
    mode = 2'b01;
    wm_thresh = 6'd0;
    do_restart();
    chk("R4 thr0 level0", int'(wm_flag), 0);
    burst(1'b1, 1'b0, 1);
    chk("R4 thr0 above", int'(wm_flag), 1);
    burst(1'b0, 1'b1, 1);
    chk("R4 thr0 equal holds", int'(wm_flag), 1);

    // R4 threshold 63
    wm_thresh = 6'd63;
    do_restart();
    burst(1'b1, 1'b0, 63);
    chk("R4 thr63 equal", int'(wm_flag), 0);
    burst(1'b1, 1'b0, 1);
    chk("R4 thr63 full", int'(wm_flag), 1);
    burst(1'b0, 1'b1, 2);
    check_all(62, 0, 0, 0, 0, 0, 0, "R7");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule